// File: doc/BRIEF.md
# Adaptive Equalizer Lock-Mode Controller

This block decides, cycle by cycle, whether an adaptive equalization engine may keep adapting, must hold its current setting, or must start adapting again from scratch. A 2-bit mode field picks one of four behaviours. The other inputs are the engine's locked flag, a signal-present flag and an invert control. The analog equalizer, the cable-length estimate and the adaptation algorithm are outside the block and appear only as those inputs.

In the two lock modes, adaptation is held once the engine reports lock. One lock mode re-arms after the input signal has been absent for at least a parameterised number of clock cycles and has then come back. The other re-arms only on a hardware reset or on a software reset. A software reset is made by moving the mode field from continuous update directly to lock-until-reset. Manual mode hands control to fixed settings and turns off automatic polarity correction, so that polarity follows the invert control. Each re-arm is signalled to the engine as a single-cycle restart request.

Top module: `eq_lock_ctrl`

## Requirements
- R1: Mode encoding is 00 continuous update, 01 lock until signal loss, 10 lock until reset and 11 manual. In mode 11, `manual_o`, `pol_auto_dis_o` and `freeze_o` are all high. In every other mode, `manual_o` and `pol_auto_dis_o` are low.
- R2: In mode 00, `freeze_o` is never high.
- R3: In modes 01 and 10, `freeze_o` goes high in the cycle after a clock edge that sees `locked_i` high. It stays high until a restart pulse or a mode change out of the lock modes.
- R4: In mode 01, a loss of `sig_present_i` lasting `LOSS_CYCLES` or more consecutive cycles produces exactly one restart pulse after the signal is seen present again. The pulse comes within two cycles.
- R5: In mode 01, a loss lasting fewer than `LOSS_CYCLES` consecutive cycles produces no restart pulse.
- R6: A change of the mode field directly from 00 to 10 between two clock edges produces a restart pulse in the cycle after the edge that sees 10. Entering mode 10 from 01 or 11 produces none. In mode 10, a signal loss of any length produces none.
- R7: Toggling `invert_i` never causes a restart pulse and never changes `freeze_o`.
- R8: `pol_invert_o` equals `invert_i` in mode 11 and is low in every other mode.
- R9: `restart_o` is never high in two consecutive cycles. A request that arrives during a pulse merges into it. In the cycle after a pulse, `freeze_o` is low unless the mode is 11.
- R10: While `rst_n` is low, `restart_o` is low and no state is held. After release, exactly one restart pulse is issued, in the cycle after the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mode_i | input | 2 | Operating mode field |
| locked_i | input | 1 | Adaptation engine reports lock |
| sig_present_i | input | 1 | Input signal detected |
| invert_i | input | 1 | Invert control (pin or software bit, already merged) |
| freeze_o | output | 1 | Hold the adaptation at its current setting |
| restart_o | output | 1 | Single-cycle request to restart adaptation |
| manual_o | output | 1 | Select the manual override settings |
| pol_auto_dis_o | output | 1 | Disable automatic polarity correction |
| pol_invert_o | output | 1 | Forced polarity inversion while automatic correction is off |

## Verification
The bench builds the block with `LOSS_CYCLES` set to 8. At that value, a loss of one cycle short of the timeout and a loss well past it both fit in a few dozen cycles, so both sides of the timeout boundary can be exercised directly. With this value, the saturation of the loss counter and the return of the signal in the cycle where the pending flag is set are also exercised together with software resets, mode hopping and invert toggling.

// File: rtl/eq_lock_ctrl.sv
module eq_lock_ctrl #(
  parameter int unsigned LOSS_CYCLES = 27000,
  localparam int unsigned CW = $clog2(LOSS_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       locked_i,
  input  logic       sig_present_i,
  input  logic       invert_i,
  output logic       freeze_o,
  output logic       restart_o,
  output logic       manual_o,
  output logic       pol_auto_dis_o,
  output logic       pol_invert_o
);

  localparam logic [1:0] M_CONT = 2'b00;
  localparam logic [1:0] M_LOSS = 2'b01;
  localparam logic [1:0] M_HOLD = 2'b10;
  localparam logic [1:0] M_MAN  = 2'b11;
  localparam logic [CW-1:0] LOSS_TC = CW'(LOSS_CYCLES);

  logic [1:0]    mode_q;
  logic [CW-1:0] loss_cnt;
  logic          pend_q, frozen_q, boot_q, restart_q;

  wire in_loss  = mode_i == M_LOSS;
  wire in_hold  = mode_i == M_HOLD;
  wire in_lock  = in_loss | in_hold;
  wire in_man   = mode_i == M_MAN;

  wire back_req = in_loss & pend_q & sig_present_i;
  wire sw_req   = in_hold & (mode_q == M_CONT);
  wire req      = boot_q | back_req | sw_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_CONT;
      loss_cnt  <= '0;
      pend_q    <= 1'b0;
      frozen_q  <= 1'b0;
      boot_q    <= 1'b1;
      restart_q <= 1'b0;
    end else begin
      mode_q    <= mode_i;
      boot_q    <= 1'b0;
      restart_q <= req & ~restart_q;

      if (sig_present_i)
        loss_cnt <= '0;
      else if (loss_cnt != LOSS_TC)
        loss_cnt <= loss_cnt + 1'b1;

      if (!in_loss || back_req)
        pend_q <= 1'b0;
      else if (loss_cnt == LOSS_TC)
        pend_q <= 1'b1;

      if (!in_lock || restart_q)
        frozen_q <= 1'b0;
      else if (locked_i)
        frozen_q <= 1'b1;
    end
  end

  assign restart_o      = restart_q;
  assign freeze_o       = in_man | (in_lock & frozen_q);
  assign manual_o       = in_man;
  assign pol_auto_dis_o = in_man;
  assign pol_invert_o   = in_man & invert_i;

endmodule

module eq_lock_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       locked_i,
  input logic       freeze_o,
  input logic       restart_o,
  input logic       manual_o,
  input logic       pol_invert_o
);

  // R9
  restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);

  // R9
  restart_unfreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> (!freeze_o || mode_i == 2'b11));

  // R2
  cont_nofreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'b00 |-> !freeze_o);

  // R3
  freeze_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(freeze_o) && mode_i != 2'b11) |-> $past(locked_i));

  // R8
  pol_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i != 2'b11 |-> !pol_invert_o);

  // R1
  manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'b11 |-> (manual_o && freeze_o));

endmodule

bind eq_lock_ctrl eq_lock_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .locked_i(locked_i),
  .freeze_o(freeze_o), .restart_o(restart_o), .manual_o(manual_o),
  .pol_invert_o(pol_invert_o)
);

// File: tb/test_eq_lock_ctrl.sv
module test_eq_lock_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LOSS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic locked = 1'b0, sig = 1'b1, inv = 1'b0;
  logic freeze, restart, manual, pdis, pinv;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eq_lock_ctrl #(.LOSS_CYCLES(LOSS)) i_eq_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .locked_i(locked),
    .sig_present_i(sig), .invert_i(inv), .freeze_o(freeze),
    .restart_o(restart), .manual_o(manual), .pol_auto_dis_o(pdis),
    .pol_invert_o(pinv));

  // behavioural reference
  int   ref_absent;
  bit   ref_pending, ref_frozen, ref_pulse, ref_boot;
  logic [1:0] ref_last;

  always @(posedge clk or negedge rst_n) begin
    bit back, sw, want;
    if (!rst_n) begin
      ref_absent = 0; ref_pending = 0; ref_frozen = 0;
      ref_pulse = 0; ref_boot = 1; ref_last = 2'b00;
    end else begin
      back = (mode == 2'b01) && ref_pending && sig;
      sw   = (mode == 2'b10) && (ref_last == 2'b00);
      want = (ref_boot || back || sw) && !ref_pulse;
      if (!(mode == 2'b01 || mode == 2'b10) || ref_pulse) ref_frozen = 0;
      else if (locked) ref_frozen = 1;
      if (mode != 2'b01 || back) ref_pending = 0;
      else if (ref_absent >= LOSS) ref_pending = 1;
      ref_absent = sig ? 0 : (ref_absent < LOSS ? ref_absent + 1 : LOSS);
      ref_pulse = want;
      ref_boot = 0;
      ref_last = mode;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit ef;
    ef = (mode == 2'b11) || ((mode == 2'b01 || mode == 2'b10) && ref_frozen);
    check(restart == ref_pulse, "R9 restart vs model", restart, ref_pulse);
    check(freeze == ef, "R3 freeze vs model", freeze, ef);
    check(manual == (mode == 2'b11) && pdis == (mode == 2'b11),
          "R1 manual/pol_dis vs model", {manual, pdis}, {2{mode == 2'b11}});
    check(pinv == ((mode == 2'b11) && inv), "R8 pol_invert vs model",
          pinv, (mode == 2'b11) && inv);
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #(CLK_PERIOD/4); end
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin step(); if (restart) cnt++; end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    int p;
    step(2);
    check(restart == 0 && freeze == 0, "R10 reset state", {restart, freeze}, 0);
    rst_n = 1'b1;
    step();
    check(restart == 1, "R10 boot pulse", restart, 1);
    step();
    check(restart == 0, "R10 boot pulse single", restart, 0);

    locked = 1; step(5);
    check(freeze == 0, "R2 continuous never freezes", freeze, 0);

    mode = 2'b01; step();
    check(freeze == 1, "R3 freeze after lock", freeze, 1);

    sig = 0; step(LOSS - 1); sig = 1;
    count_pulses(6, p);
    check(p == 0, "R5 short loss no restart", p, 0);
    check(freeze == 1, "R5 still frozen", freeze, 1);

    sig = 0; locked = 0; step(LOSS + 3); sig = 1;
    count_pulses(4, p);
    check(p == 1, "R4 long loss one restart", p, 1);
    check(freeze == 0, "R9 unfrozen after restart", freeze, 0);

    sig = 0; step(LOSS); sig = 1;
    count_pulses(4, p);
    check(p == 1, "R4 loss of exactly timeout", p, 1);

    locked = 1; step();
    mode = 2'b10; count_pulses(3, p);
    check(p == 0, "R6 no restart entering 10 from 01", p, 0);
    check(freeze == 1, "R3 frozen in lock-until-reset", freeze, 1);

    repeat (4) begin inv = ~inv; step(); end
    count_pulses(3, p);
    check(p == 0, "R7 invert toggles no restart", p, 0);
    check(freeze == 1, "R7 invert keeps freeze", freeze, 1);

    sig = 0; step(LOSS + 4); sig = 1;
    count_pulses(4, p);
    check(p == 0, "R6 loss ignored in mode 10", p, 0);

    mode = 2'b00; step(); mode = 2'b10; locked = 0;
    count_pulses(3, p);
    check(p == 1, "R6 software reset 00 then 10", p, 1);
    check(freeze == 0, "R9 freeze cleared by software reset", freeze, 0);

    mode = 2'b11; inv = 1; step();
    check(manual && pdis && freeze, "R1 manual outputs", {manual, pdis, freeze}, 7);
    check(pinv == 1, "R8 polarity follows invert high", pinv, 1);
    inv = 0; step();
    check(pinv == 0, "R8 polarity follows invert low", pinv, 0);
    mode = 2'b10; count_pulses(3, p);
    check(p == 0, "R6 no restart entering 10 from 11", p, 0);

    mode = 2'b00; step(); mode = 2'b10; step(); mode = 2'b00; step(); mode = 2'b10;
    step(4);

    rst_n = 0; step(2);
    check(restart == 0, "R10 reset mid-run", restart, 0);
    rst_n = 1; count_pulses(4, p);
    check(p == 1, "R10 one pulse after release", p, 1);

    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired R10 actual=0 expected=1");
    finish_run();
  end
endmodule